// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the entry into an exception handler for a small 8-bit processor. It runs cycle by cycle and covers four causes: the software break instruction, the maskable interrupt, the non-maskable interrupt and reset. A one-cycle `start` pulse, qualified by a two-bit cause code, captures the program counter, stack pointer and status flags. The block then drives a byte-wide memory bus. Read data on that bus comes back in the same cycle. The block pushes the return state onto the page-one stack and fetches the 16-bit handler address from a fixed vector.

A break or maskable sequence that has already started can be redirected to the non-maskable handler. This happens if a non-maskable request is pending at the zero-time step where the vector is chosen. The block acknowledges the request at that step so that the edge detector can clear it. Reset goes through the same three stack steps, but its writes are suppressed, so each step becomes a read of the stack address. When the handler address has been loaded, the block pulses `done` for one clock. The surrounding core then takes `pc_out`, `sp_out` and `iflag_out`.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle: `busy`, `done`, `mem_we` and `nmi_ack` are all 0 after that edge.
- R2: Cause code 2'b00 (break) pushes three bytes in three consecutive cycles, starting the cycle after `start`. The first is the high byte of `pc_in`+1 (modulo 2^16), written at 0x0100|S. The second is the low byte, written at 0x0100|(S-1). The third is the status byte: `flags_in` with bit 4 forced to 1, written at 0x0100|(S-2). S arithmetic wraps modulo 256.
- R3: Cause code 2'b01 (maskable) pushes the same three bytes in the same cycles, with two differences: the unincremented `pc_in` is pushed, and status bit 4 is forced to 0. Cause code 2'b10 (non-maskable) pushes the same bytes as the maskable case.
- R4: The two cycles after the pushes are reads with `mem_we` low. The first reads the vector address and loads PC[7:0]. The second reads the vector address plus one and loads PC[15:8]. The vector is 0xFFFA for non-maskable, 0xFFFC for reset, and 0xFFFE for break and maskable.
- R5: During a break or maskable sequence, `nmi_pending` is sampled in the second push cycle. If it is high there, the vector becomes 0xFFFA and `nmi_ack` is high in that same cycle. If it is high in any other cycle, it has no effect and `nmi_ack` stays low.
- R6: Cause code 2'b11 (reset) drives the three stack addresses with `mem_we` low, then reads vector 0xFFFC. `sp_out` ends three below `sp_in` for every cause.
- R7: For break, maskable and non-maskable causes, `iflag_out` is 1 from the first vector read onward. For reset, `iflag_out` equals bit 2 of `flags_in`.
- R8: `done` is high for exactly one cycle: the sixth cycle after the `start` edge, directly after the high vector byte is read. `busy` is high from the first push cycle through the `done` cycle.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The running sequence finishes with the addresses, data and results of the original cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an entry sequence (accepted only when idle) |
| kind | input | 2 | Cause: 00 break, 01 maskable, 10 non-maskable, 11 reset |
| nmi_pending | input | 1 | A non-maskable request is pending |
| pc_in | input | 16 | Program counter at entry |
| sp_in | input | 8 | Stack pointer at entry |
| flags_in | input | 8 | Status flags at entry |
| mem_rdata | input | 8 | Read data, valid in the same cycle |
| mem_addr | output | 16 | Bus address |
| mem_we | output | 1 | Bus write enable |
| mem_wdata | output | 8 | Bus write data |
| nmi_ack | output | 1 | Pending non-maskable request was consumed |
| pc_out | output | 16 | Program counter (handler address after done) |
| sp_out | output | 8 | Stack pointer |
| iflag_out | output | 1 | Interrupt-disable flag |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check several properties. Writes land only on the stack page, and a reset sequence never writes. The stack pointer steps down by one in each stack cycle. `nmi_ack` appears only when a request is pending, and `done` is a single-cycle pulse with the interrupt-disable flag set for non-reset causes. Other behaviours can only be shown by the bench's directed scenarios. These include the exact byte order and values on the bus, which vector each cause and each `nmi_pending` timing selects, the handler address assembled from the two reads, stack wrap-around, and a second `start` being ignored.

// File: rtl/irq_entry_pkg.sv
// Package: shared types for the interrupt entry sequencer.
// Assumes: the cause encoding below is fixed by the core's decoder.
package irq_entry_pkg;
    typedef enum logic [1:0] {
        K_BRK = 2'b00,
        K_IRQ = 2'b01,
        K_NMI = 2'b10,
        K_RST = 2'b11
    } entry_kind_t;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_PUSH_H = 3'd1,
        S_PUSH_L = 3'd2,
        S_PUSH_P = 3'd3,
        S_VEC_L  = 3'd4,
        S_VEC_H  = 3'd5,
        S_DONE   = 3'd6
    } seq_state_t;
endpackage

// File: rtl/ies_vec_sel.sv
// Module: ies_vec_sel
// Picks the handler vector address for the running cause. At the pick step of
// a break or maskable sequence, a pending non-maskable request redirects the
// vector and is acknowledged. Assumes: pick is high for exactly one cycle.
module ies_vec_sel
    import irq_entry_pkg::*;
#(
    parameter int AW = 16,
    parameter logic [AW-1:0] VEC_NMI = 16'hFFFA,
    parameter logic [AW-1:0] VEC_RST = 16'hFFFC,
    parameter logic [AW-1:0] VEC_BRK = 16'hFFFE
) (
    input  entry_kind_t   kind,
    input  logic          pick,
    input  logic          nmi_pending,
    output logic [AW-1:0] vec,
    output logic          take_nmi
);
    // Decide the vector and whether a pending non-maskable request usurps it.
    always_comb begin
        take_nmi = 1'b0;
        unique case (kind)
            K_NMI: vec = VEC_NMI;
            K_RST: vec = VEC_RST;
            default: begin
                if (nmi_pending) begin
                    vec      = VEC_NMI;
                    take_nmi = pick;
                end else begin
                    vec = VEC_BRK;
                end
            end
        endcase
    end
endmodule

// File: rtl/ies_stat_fmt.sv
// Module: ies_stat_fmt
// Forms the status byte pushed on entry: the captured flags with the break
// marker forced set for a software break and clear for any other cause.
module ies_stat_fmt #(
    parameter int DW      = 8,
    parameter int BRK_BIT = 4
) (
    input  logic [DW-1:0] flags,
    input  logic          is_brk,
    output logic [DW-1:0] stat
);
    // Overwrite only the break marker bit.
    always_comb begin
        stat          = flags;
        stat[BRK_BIT] = is_brk;
    end
endmodule

// File: rtl/ies_bus_drv.sv
// Module: ies_bus_drv
// Drives the byte bus from the sequencer state: stack cycles address the
// stack page, vector cycles address the vector and vector+1. Writes are
// suppressed when a reset sequence runs. Assumes the stack page is fixed.
module ies_bus_drv
    import irq_entry_pkg::*;
#(
    parameter int DW = 8,
    parameter logic [DW-1:0] STACK_PAGE = 8'h01,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_state_t    state,
    input  logic [DW-1:0] sp,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] stat,
    input  logic [AW-1:0] vec,
    input  logic          no_write,
    output logic [AW-1:0] addr,
    output logic          we,
    output logic [DW-1:0] wdata
);
    // Select address, data and write strobe for the current step.
    always_comb begin
        addr  = '0;
        we    = 1'b0;
        wdata = '0;
        unique case (state)
            S_PUSH_H: begin addr = {STACK_PAGE, sp}; we = !no_write; wdata = pc[AW-1:DW]; end
            S_PUSH_L: begin addr = {STACK_PAGE, sp}; we = !no_write; wdata = pc[DW-1:0]; end
            S_PUSH_P: begin addr = {STACK_PAGE, sp}; we = !no_write; wdata = stat; end
            S_VEC_L:  addr = vec;
            S_VEC_H:  addr = vec + AW'(1);
            default: ;
        endcase
    end

    // Writes may only ever target the stack page (R2).
    a_r2_write_on_stack: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> addr[AW-1:DW] == STACK_PAGE);
    // Vector cycles never write (R4).
    a_r4_vector_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_VEC_L || state == S_VEC_H) |-> !we);
endmodule

// File: rtl/irq_entry_seq.sv
// Module: irq_entry_seq (top)
// Sequences exception entry: three stack steps (writes, or reads for reset),
// a zero-time vector pick and flag set, two vector reads, then a done pulse.
// Assumes read data returns combinationally in the same cycle.
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int DW       = 8,
    parameter int BRK_BIT  = 4,
    parameter int IDIS_BIT = 2,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    kind,
    input  logic          nmi_pending,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] sp_in,
    input  logic [DW-1:0] flags_in,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic          nmi_ack,
    output logic [AW-1:0] pc_out,
    output logic [DW-1:0] sp_out,
    output logic          iflag_out,
    output logic          busy,
    output logic          done
);
    seq_state_t    state;
    entry_kind_t   kind_r;
    logic [AW-1:0] pc_r;
    logic [AW-1:0] vec_r;
    logic [AW-1:0] vec_w;
    logic [DW-1:0] sp_r;
    logic [DW-1:0] flags_r;
    logic [DW-1:0] stat_w;
    logic          iflag_r;
    logic          take_nmi;
    logic          is_rst;

    assign is_rst = (kind_r == K_RST);

    ies_vec_sel #(.AW(AW)) u_vec (
        .kind(kind_r), .pick(state == S_PUSH_L), .nmi_pending(nmi_pending),
        .vec(vec_w), .take_nmi(take_nmi)
    );

    ies_stat_fmt #(.DW(DW), .BRK_BIT(BRK_BIT)) u_stat (
        .flags(flags_r), .is_brk(kind_r == K_BRK), .stat(stat_w)
    );

    ies_bus_drv #(.DW(DW)) u_bus (
        .clk(clk), .rst_n(rst_n), .state(state), .sp(sp_r), .pc(pc_r),
        .stat(stat_w), .vec(vec_r), .no_write(is_rst),
        .addr(mem_addr), .we(mem_we), .wdata(mem_wdata)
    );

    // Step the sequence and update the architectural registers it owns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            kind_r  <= K_BRK;
            pc_r    <= '0;
            vec_r   <= '0;
            sp_r    <= '0;
            flags_r <= '0;
            iflag_r <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    kind_r  <= entry_kind_t'(kind);
                    pc_r    <= pc_in + {{(AW-1){1'b0}}, (kind == K_BRK)};
                    sp_r    <= sp_in;
                    flags_r <= flags_in;
                    iflag_r <= flags_in[IDIS_BIT];
                    state   <= S_PUSH_H;
                end
                S_PUSH_H: begin
                    sp_r  <= sp_r - DW'(1);
                    state <= S_PUSH_L;
                end
                S_PUSH_L: begin
                    sp_r  <= sp_r - DW'(1);
                    vec_r <= vec_w;
                    state <= S_PUSH_P;
                end
                S_PUSH_P: begin
                    sp_r <= sp_r - DW'(1);
                    if (!is_rst) iflag_r <= 1'b1;
                    state <= S_VEC_L;
                end
                S_VEC_L: begin
                    pc_r[DW-1:0] <= mem_rdata;
                    state        <= S_VEC_H;
                end
                S_VEC_H: begin
                    pc_r[AW-1:DW] <= mem_rdata;
                    state         <= S_DONE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign nmi_ack   = take_nmi;
    assign pc_out    = pc_r;
    assign sp_out    = sp_r;
    assign iflag_out = iflag_r;
    assign busy      = (state != S_IDLE);
    assign done      = (state == S_DONE);

    // Each stack step lowers the stack pointer by one (R6).
    a_r6_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PUSH_H || state == S_PUSH_L || state == S_PUSH_P)
        |=> sp_r == DW'($past(sp_r) - DW'(1)));
    // A reset sequence never writes the bus (R6).
    a_r6_reset_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_rst) |-> !mem_we);
    // An acknowledge only answers a pending request (R5).
    a_r5_ack_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_ack |-> nmi_pending);
    // Done is a single-cycle pulse (R8).
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // Non-reset causes finish with interrupts disabled (R7).
    a_r7_iflag_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !is_rst) |-> iflag_out);
    // Once started, a sequence stays busy until done (R9).
    a_r9_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: tb/sim_irq_entry_seq.sv
// Directed bench for irq_entry_seq: one task per scenario, each checking
// its own bus trace and results against values computed from the brief.
module sim_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  kind = 2'b00;
    logic        nmi_pending = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  sp_in = '0;
    logic [7:0]  flags_in = '0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic        nmi_ack;
    logic [15:0] pc_out;
    logic [7:0]  sp_out;
    logic        iflag_out;
    logic        busy;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    // Bench memory: every byte reads as its low address byte plus 0x11.
    assign mem_rdata = mem_addr[7:0] + 8'h11;

    irq_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .kind(kind),
        .nmi_pending(nmi_pending), .pc_in(pc_in), .sp_in(sp_in),
        .flags_in(flags_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .nmi_ack(nmi_ack),
        .pc_out(pc_out), .sp_out(sp_out), .iflag_out(iflag_out),
        .busy(busy), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rd(input logic [15:0] a);
        return {8'h00, a[7:0] + 8'h11};
    endfunction

    // Run one sequence. nmi_cyc: cycle (1..6) in which nmi_pending is high, 0 none.
    // restart: pulse start again with the reset cause in cycle 2.
    task automatic run_seq(input string tag, input logic [1:0] k, input logic [15:0] pc,
                           input logic [7:0] sp, input logic [7:0] fl,
                           input int nmi_cyc, input bit restart);
        logic [15:0] ppc;
        logic [7:0]  st;
        logic [15:0] vec;
        bit          take;
        bit          rst_k;
        rst_k = (k == 2'b11);
        ppc   = (k == 2'b00) ? pc + 16'd1 : pc;
        st    = fl;
        st[4] = (k == 2'b00);
        take  = (k == 2'b00 || k == 2'b01) && nmi_cyc == 2;
        vec   = (k == 2'b10 || take) ? 16'hFFFA : (rst_k ? 16'hFFFC : 16'hFFFE);
        @(negedge clk);
        start = 1'b1; kind = k; pc_in = pc; sp_in = sp; flags_in = fl;
        @(posedge clk);
        for (int c = 1; c <= 7; c++) begin
            if (c > 1) @(posedge clk);
            #1;
            start       = restart && c == 2;
            kind        = restart ? 2'b11 : k;
            nmi_pending = (c == nmi_cyc);
            @(negedge clk);
            case (c)
                1: begin
                    chk({tag, " R2/R6 addr1"}, 32'(mem_addr), 32'({8'h01, sp}));
                    chk({tag, " R2/R6 we1"}, 32'(mem_we), 32'(!rst_k));
                    if (!rst_k) chk({tag, " R2/R3 pch"}, 32'(mem_wdata), 32'(ppc[15:8]));
                    chk({tag, " R8 busy"}, 32'(busy), 32'd1);
                    chk({tag, " R5 ack1"}, 32'(nmi_ack), 32'd0);
                end
                2: begin
                    chk({tag, " R2/R6 addr2"}, 32'(mem_addr), 32'({8'h01, 8'(sp - 8'd1)}));
                    chk({tag, " R2/R6 we2"}, 32'(mem_we), 32'(!rst_k));
                    if (!rst_k) chk({tag, " R2/R3 pcl"}, 32'(mem_wdata), 32'(ppc[7:0]));
                    chk({tag, " R5 ack2"}, 32'(nmi_ack), 32'(take));
                end
                3: begin
                    chk({tag, " R2/R6 addr3"}, 32'(mem_addr), 32'({8'h01, 8'(sp - 8'd2)}));
                    chk({tag, " R2/R6 we3"}, 32'(mem_we), 32'(!rst_k));
                    if (!rst_k) chk({tag, " R2/R3 status"}, 32'(mem_wdata), 32'(st));
                    chk({tag, " R5 ack3"}, 32'(nmi_ack), 32'd0);
                end
                4: begin
                    chk({tag, " R4 vec lo addr"}, 32'(mem_addr), 32'(vec));
                    chk({tag, " R4 we lo"}, 32'(mem_we), 32'd0);
                    chk({tag, " R7 iflag"}, 32'(iflag_out), rst_k ? 32'(fl[2]) : 32'd1);
                end
                5: begin
                    chk({tag, " R4 vec hi addr"}, 32'(mem_addr), 32'(vec + 16'd1));
                    chk({tag, " R8 no early done"}, 32'(done), 32'd0);
                end
                6: begin
                    chk({tag, " R8 done"}, 32'(done), 32'd1);
                    chk({tag, " R4 pc_out"}, 32'(pc_out), 32'({rd(vec + 16'd1)[7:0], rd(vec)[7:0]}));
                    chk({tag, " R6 sp_out"}, 32'(sp_out), 32'(8'(sp - 8'd3)));
                    chk({tag, " R7 iflag end"}, 32'(iflag_out), rst_k ? 32'(fl[2]) : 32'd1);
                end
                default: begin
                    chk({tag, " R8 done falls"}, 32'(done), 32'd0);
                    chk({tag, " R8 idle"}, 32'(busy), 32'd0);
                    chk({tag, " R9 no restart"}, 32'(busy), 32'd0);
                end
            endcase
        end
        nmi_pending = 1'b0;
        start = 1'b0;
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 we", 32'(mem_we), 32'd0);
        chk("R1 ack", 32'(nmi_ack), 32'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        t_reset_state();
        run_seq("brk", 2'b00, 16'h1234, 8'hFD, 8'h22, 0, 1'b0);
        run_seq("brk pc wrap", 2'b00, 16'hFFFF, 8'h80, 8'hC3, 0, 1'b0);
        run_seq("irq", 2'b01, 16'hABCD, 8'hF0, 8'h3B, 0, 1'b0);
        run_seq("irq flag clear", 2'b01, 16'h0202, 8'h10, 8'h04, 0, 1'b0);
        run_seq("nmi", 2'b10, 16'h4000, 8'h77, 8'h10, 0, 1'b0);
        run_seq("rst", 2'b11, 16'h5555, 8'h00, 8'h00, 0, 1'b0);
        run_seq("rst iset", 2'b11, 16'h5555, 8'h40, 8'h04, 0, 1'b0);
        run_seq("sp wrap", 2'b00, 16'h0100, 8'h01, 8'h00, 0, 1'b0);
        run_seq("brk takeover", 2'b00, 16'h2000, 8'hFF, 8'h00, 2, 1'b0);
        run_seq("irq takeover", 2'b01, 16'h3000, 8'hFF, 8'h00, 2, 1'b0);
        run_seq("irq late nmi", 2'b01, 16'h3000, 8'hFF, 8'h00, 3, 1'b0);
        run_seq("brk early nmi", 2'b00, 16'h3000, 8'hFF, 8'h00, 1, 1'b0);
        run_seq("brk restart", 2'b00, 16'h6789, 8'hA0, 8'h81, 0, 1'b1);
        t_reset_state();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule